// File: doc/BRIEF.md
# Strap-Selected NAND Chain Connectivity Test Mode

This block gives a small mixed-signal device a board-level connectivity test. Some clock cycles after the power-on reset is released, it reads a strap pin once. If the strap is high at that moment, the device stays in test mode until the next power-on reset. If the strap is low, it stays in normal mode.

In test mode, the six digital inputs feed a chain of two-input NAND gates. The two serial-bus lines are taps 5 and 4, and the four voltage-ID lines are taps 3 down to 0. The output of the chain drives the shared address/interrupt pin in place of its normal function.

Tap 0 is farthest from the output. It meets a constant high in the first stage. Tap 5 is nearest the output and enters the last stage. Test equipment drives every input low, then raises the taps one by one from tap 5 down to tap 0 and leaves each one high. The pin toggles at every step. Outside test mode, the pin carries the normal function value and the chain has no effect.

Top module: `pintest_ctrl`

## Requirements
- R1: While `por` is high and after it falls, `test_mode` reads 0 and `pin_drive` equals `func_val`, until the strap sampling edge.
- R2: The strap is sampled on exactly the SAMPLE_DELAY-th rising clock edge with `por` low (default 8). Before that edge, `test_mode` stays 0 whatever the strap value.
- R3: `test_mode` becomes 1 if `strap_in` was high at the sampling edge, and stays 0 if it was low.
- R4: After the sampling edge, changes on `strap_in` have no effect on `test_mode` until the next power-on reset.
- R5: In test mode, `pin_drive` equals stage 5 of the chain. Stage k is NAND(`dig_in[k]`, stage k-1), and stage -1 is a constant 1.
- R6: In test mode with all of `dig_in` low, `pin_drive` is 1. Raising bits 5, 4, 3, 2, 1, 0 in turn, each left high, toggles `pin_drive` at every step, giving 0,1,0,1,0,1.
- R7: In test mode, `func_val` has no effect on `pin_drive`.
- R8: In normal mode, `pin_drive` equals `func_val` and `dig_in` has no effect.
- R9: A new power-on reset clears the latched mode, and the strap is sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| strap_in | input | 1 | Test-mode strap pin |
| dig_in | input | 6 | Digital inputs; bits 5,4 are bus data/clock, bits 3..0 voltage-ID; bit 5 nearest the output |
| func_val | input | 1 | Normal-function value for the shared pin |
| pin_drive | output | 1 | Value driven onto the shared address/interrupt pin |
| test_mode | output | 1 | High while the NAND test mode is latched |

## Verification
The hardest case to reach from the ports is the single sampling edge. The strap has to hold a chosen value exactly at the SAMPLE_DELAY-th edge after reset release, and the mode must not move one edge earlier or at any edge later. The bench releases `por` at a falling clock edge and counts rising edges from there. It checks `test_mode` at the edge just before the sampling edge and at the sampling edge itself. It then toggles the strap on many later cycles to show that the mode no longer follows it. The walking-one sequence only matters once that latch holds a 1, so the chain checks run after a strap-high power-up.

// File: rtl/pintest_pkg.sv
package pintest_pkg;

    localparam int unsigned DEF_TAPS  = 6;
    localparam int unsigned DEF_DELAY = 8;

    typedef enum logic {
        SS_COUNT  = 1'b0,
        SS_LOCKED = 1'b1
    } strap_state_e;

    typedef struct packed {
        strap_state_e state;
        logic         test_en;
    } strap_stat_t;

    function automatic logic nand2(input logic a, input logic b);
        return ~(a & b);
    endfunction

endpackage

// File: rtl/pintest_strap.sv
module pintest_strap
    import pintest_pkg::*;
#(
    parameter int unsigned DELAY = DEF_DELAY
) (
    input  logic        clk,
    input  logic        por,
    input  logic        strap_in,
    output strap_stat_t stat
);

    localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;
    strap_stat_t   stat_q;

    always_ff @(posedge clk) begin
        if (por) begin
            cnt_q          <= '0;
            stat_q.state   <= SS_COUNT;
            stat_q.test_en <= 1'b0;
        end else if (stat_q.state == SS_COUNT) begin
            if (cnt_q == LAST) begin
                stat_q.state   <= SS_LOCKED;
                stat_q.test_en <= strap_in;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign stat = stat_q;

    AST_NO_MODE_BEFORE_LOCK: assert property (@(posedge clk) disable iff (por)
        (stat_q.state == SS_COUNT) |-> !stat_q.test_en); // R2

    AST_LOCK_TAKES_STRAP: assert property (@(posedge clk) disable iff (por)
        $rose(stat_q.state == SS_LOCKED) |-> (stat_q.test_en == $past(strap_in))); // R3

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (por)
        $past(stat_q.state == SS_LOCKED) |-> $stable(stat_q.test_en)); // R4

endmodule

// File: rtl/pintest_chain.sv
module pintest_chain
    import pintest_pkg::*;
#(
    parameter int unsigned TAPS = DEF_TAPS
) (
    input  logic [TAPS-1:0] taps,
    output logic            tree_out
);

    logic [TAPS-1:0] stage;

    for (genvar g = 0; g < TAPS; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage[g] = nand2(taps[g], 1'b1);
        end else begin : g_link
            assign stage[g] = nand2(taps[g], stage[g-1]);
        end
    end

    assign tree_out = stage[TAPS-1];

endmodule

// File: rtl/pintest_padsel.sv
module pintest_padsel (
    input  logic test_en,
    input  logic tree_out,
    input  logic func_val,
    output logic pin_drive
);

    always_comb begin
        if (test_en) pin_drive = tree_out;
        else         pin_drive = func_val;
    end

endmodule

// File: rtl/pintest_ctrl.sv
module pintest_ctrl
    import pintest_pkg::*;
#(
    parameter int unsigned TAPS  = DEF_TAPS,
    parameter int unsigned DELAY = DEF_DELAY
) (
    input  logic            clk,
    input  logic            por,
    input  logic            strap_in,
    input  logic [TAPS-1:0] dig_in,
    input  logic            func_val,
    output logic            pin_drive,
    output logic            test_mode
);

    strap_stat_t stat;
    logic        tree_out;

    pintest_strap #(.DELAY(DELAY)) u_strap (
        .clk      (clk),
        .por      (por),
        .strap_in (strap_in),
        .stat     (stat)
    );

    pintest_chain #(.TAPS(TAPS)) u_chain (
        .taps     (dig_in),
        .tree_out (tree_out)
    );

    pintest_padsel u_padsel (
        .test_en   (stat.test_en),
        .tree_out  (tree_out),
        .func_val  (func_val),
        .pin_drive (pin_drive)
    );

    assign test_mode = stat.test_en;

    AST_NEAR_TAP_LOW_HIGH: assert property (@(posedge clk) disable iff (por)
        (test_mode && !dig_in[TAPS-1]) |-> pin_drive); // R5

    AST_ALL_LOW_HIGH: assert property (@(posedge clk) disable iff (por)
        (test_mode && (dig_in == '0)) |-> pin_drive); // R6

endmodule

// File: tb/pintest_ctrl_test.sv
module pintest_ctrl_test;

    localparam int TAPS  = 6;
    localparam int DELAY = 8;

    logic            clk = 1'b0;
    logic            por = 1'b1;
    logic            strap_in = 1'b0;
    logic [TAPS-1:0] dig_in = '0;
    logic            func_val = 1'b0;
    logic            pin_drive;
    logic            test_mode;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pintest_ctrl #(.TAPS(TAPS), .DELAY(DELAY)) uut (
        .clk(clk), .por(por), .strap_in(strap_in), .dig_in(dig_in),
        .func_val(func_val), .pin_drive(pin_drive), .test_mode(test_mode)
    );

    function automatic logic chain_ref(input logic [TAPS-1:0] v);
        logic s = 1'b1;
        for (int k = 0; k < TAPS; k++) s = ~(v[k] & s);
        return s;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Power up with a strap value; checks R1, R2, R3 along the way.
    task automatic power_up(input logic strap_val);
        @(negedge clk);
        por = 1'b1;
        strap_in = strap_val;
        repeat (3) @(negedge clk);
        check(test_mode, 1'b0, "R1 mode in reset");
        func_val = 1'b1; #1;
        check(pin_drive, 1'b1, "R1 pin follows func in reset");
        func_val = 1'b0; #1;
        check(pin_drive, 1'b0, "R1 pin follows func in reset");
        por = 1'b0;
        repeat (DELAY - 1) @(posedge clk);
        @(negedge clk);
        check(test_mode, 1'b0, "R2 no mode before sampling edge");
        @(posedge clk);
        @(negedge clk);
        check(test_mode, strap_val, "R3 mode equals sampled strap");
    endtask

    task automatic t_hold(input logic expect_mode);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            strap_in = ~strap_in;
        end
        repeat (2) @(negedge clk);
        check(test_mode, expect_mode, "R4 strap ignored after sampling");
    endtask

    task automatic t_walk();
        logic exp;
        @(negedge clk);
        dig_in = '0; #1;
        check(pin_drive, 1'b1, "R6 all low gives high");
        exp = 1'b1;
        for (int k = TAPS - 1; k >= 0; k--) begin
            @(negedge clk);
            dig_in[k] = 1'b1; #1;
            exp = ~exp;
            check(pin_drive, exp, $sformatf("R6 toggle on raising bit %0d", k));
        end
    endtask

    task automatic t_patterns();
        logic [TAPS-1:0] pats [6] = '{6'b000000, 6'b111111, 6'b101010,
                                      6'b010101, 6'b100001, 6'b011110};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dig_in = pats[i];
            func_val = 1'b0; #1;
            check(pin_drive, chain_ref(pats[i]), "R5 chain value");
            func_val = 1'b1; #1;
            check(pin_drive, chain_ref(pats[i]), "R7 func ignored in test mode");
        end
    endtask

    task automatic t_normal();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dig_in = TAPS'(i * 13 + 5);
            func_val = i[0]; #1;
            check(pin_drive, i[0], "R8 pin follows func in normal mode");
            dig_in = ~dig_in; #1;
            check(pin_drive, i[0], "R8 inputs ignored in normal mode");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        power_up(1'b0);
        t_normal();
        t_hold(1'b0);
        power_up(1'b1);
        t_hold(1'b1);
        t_walk();
        t_patterns();
        power_up(1'b0);
        check(test_mode, 1'b0, "R9 new reset re-samples strap");
        t_normal();
        power_up(1'b1);
        check(test_mode, 1'b1, "R9 re-entered test mode");
        t_walk();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule